// File: doc/BRIEF.md
# Staged Datapath Control for a Five-Stage Pipeline

This block generates the datapath control word for a five-stage 32-bit RISC pipeline. During decode it reads the opcode field of the instruction held in the fetch/decode register and derives nine control bits. None of these bits is used in decode itself. The block carries them forward through three control registers: decode/execute, execute/memory and memory/write-back. Each stage's register holds only the bits that stage or a later stage still needs, and the block drives out only the bits the current stage uses.

The hazard logic around the block can ask for a bubble, which zeroes the control word entering the execute stage. The branch and exception logic can flush the decode/execute register or the execute/memory register, and the flushed register is zeroed on the next clock edge. In the memory stage the block combines the staged branch bit with the ALU zero flag to form the select for the branch-taken PC.

Top module: `ctrl_stage_pipe`

## Requirements
- R1: The opcode is bits 31:26 of `instr_id`. The other 26 bits have no effect on any output.
- R2: Opcode 0x23 (load word) decodes to alu_src=1, mem_to_reg=1, reg_write=1, mem_read=1 and alu_op=00. Every other control bit is 0.
- R3: Opcode 0x2B (store word) decodes to alu_src=1, mem_write=1 and alu_op=00. Every other control bit is 0. No opcode drives `mem_read` and `mem_write` high together.
- R4: Opcode 0x00 (register format) decodes to reg_dst=1, reg_write=1 and alu_op=10. Every other control bit is 0.
- R5: Opcode 0x04 (branch on equal) decodes to branch=1 and alu_op=01. Every other control bit is 0.
- R6: Any other opcode decodes to all-zero controls.
- R7: Timing of the staged outputs:
  - The `ex_*` outputs show the decoded word one clock edge after decode.
  - The `mem_*` outputs show the same word one edge later.
  - The `wb_*` outputs show it one edge after that.
- R8: When `bubble_req` is high at a clock edge, the decode/execute control register loads all zeros.
- R9: Flushing:
  - When `flush_idex` is high at an edge, the decode/execute control register becomes zero.
  - When `flush_exmem` is high at an edge, the execute/memory control register becomes zero.
  - A zeroed register passes zeros downstream on the following edges.
- R10: `mem_pc_src` is the staged memory-stage branch bit ANDed with the current `alu_zero` input, with no added register.
- R11: While `rst` is high at a clock edge, every staged control register is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_id | input | 32 | Instruction held in the fetch/decode register |
| bubble_req | input | 1 | Insert an all-zero control word into execute |
| flush_idex | input | 1 | Zero the decode/execute control register |
| flush_exmem | input | 1 | Zero the execute/memory control register |
| alu_zero | input | 1 | ALU zero flag of the instruction in the memory stage |
| ex_reg_dst | output | 1 | Execute: select rd as the destination register |
| ex_alu_src | output | 1 | Execute: select the immediate as ALU operand B |
| ex_alu_op | output | 2 | Execute: ALU operation class |
| mem_branch | output | 1 | Memory: the instruction is a conditional branch |
| mem_read | output | 1 | Memory: read data memory |
| mem_write | output | 1 | Memory: write data memory |
| mem_pc_src | output | 1 | Memory: take the branch target |
| wb_mem_to_reg | output | 1 | Write-back: write memory data rather than the ALU result |
| wb_reg_write | output | 1 | Write-back: write the register file |

## Verification
Directed single instructions of each opcode class check the decode values at each stage's output. A wrong bit shows up in exactly one stage's field. A word whose opcode field is invalid, but whose lower bits copy a valid opcode, shows whether the decoder looks only at bits 31:26. Constrained random streams mix the four opcodes, unknown opcodes, bubbles, flushes and zero flags. These streams separate the two flush points and the bubble by where in the pipe the zeros appear. They also test the branch select against the zero flag in both states.

// File: rtl/ctrl_stage_pkg.sv
package ctrl_stage_pkg;

   localparam logic [1:0] ALUOP_ADDR  = 2'b00;
   localparam logic [1:0] ALUOP_CMP   = 2'b01;
   localparam logic [1:0] ALUOP_FUNCT = 2'b10;

   typedef struct packed {
      logic       reg_dst;
      logic       alu_src;
      logic [1:0] alu_op;
   } ex_ctl_t;

   typedef struct packed {
      logic branch;
      logic rd_en;
      logic wr_en;
   } mem_ctl_t;

   typedef struct packed {
      logic mem_to_reg;
      logic reg_write;
   } wb_ctl_t;

   typedef struct packed {
      mem_ctl_t mem;
      wb_ctl_t  wb;
   } late_ctl_t;

   typedef struct packed {
      ex_ctl_t   ex;
      late_ctl_t late;
   } full_ctl_t;

endpackage

// File: rtl/ctrl_decode.sv
module ctrl_decode
   import ctrl_stage_pkg::*;
#(
   parameter int OP_W = 6,
   parameter logic [OP_W-1:0] OPC_LOAD  = 6'h23,
   parameter logic [OP_W-1:0] OPC_STORE = 6'h2B,
   parameter logic [OP_W-1:0] OPC_REG   = 6'h00,
   parameter logic [OP_W-1:0] OPC_BEQ   = 6'h04
) (
   input  logic [OP_W-1:0] opcode,
   output full_ctl_t       ctl
);

   always_comb begin
      ctl = '0;
      if (opcode == OPC_LOAD) begin
         ctl.ex.alu_src          = 1'b1;
         ctl.ex.alu_op           = ALUOP_ADDR;
         ctl.late.mem.rd_en      = 1'b1;
         ctl.late.wb.mem_to_reg  = 1'b1;
         ctl.late.wb.reg_write   = 1'b1;
      end else if (opcode == OPC_STORE) begin
         ctl.ex.alu_src          = 1'b1;
         ctl.ex.alu_op           = ALUOP_ADDR;
         ctl.late.mem.wr_en      = 1'b1;
      end else if (opcode == OPC_REG) begin
         ctl.ex.reg_dst          = 1'b1;
         ctl.ex.alu_op           = ALUOP_FUNCT;
         ctl.late.wb.reg_write   = 1'b1;
      end else if (opcode == OPC_BEQ) begin
         ctl.ex.alu_op           = ALUOP_CMP;
         ctl.late.mem.branch     = 1'b1;
      end
   end

endmodule

// File: rtl/ctrl_stage_reg.sv
module ctrl_stage_reg #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst || clr) q <= '0;
      else            q <= d;
   end

endmodule

// File: rtl/ctrl_stage_pipe.sv
module ctrl_stage_pipe
   import ctrl_stage_pkg::*;
#(
   parameter int INSTR_W = 32,
   parameter int OP_LSB  = 26,
   parameter int OP_W    = 6,
   parameter logic [OP_W-1:0] OPC_LOAD  = 6'h23,
   parameter logic [OP_W-1:0] OPC_STORE = 6'h2B,
   parameter logic [OP_W-1:0] OPC_REG   = 6'h00,
   parameter logic [OP_W-1:0] OPC_BEQ   = 6'h04
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [INSTR_W-1:0] instr_id,
   input  logic               bubble_req,
   input  logic               flush_idex,
   input  logic               flush_exmem,
   input  logic               alu_zero,
   output logic               ex_reg_dst,
   output logic               ex_alu_src,
   output logic [1:0]         ex_alu_op,
   output logic               mem_branch,
   output logic               mem_read,
   output logic               mem_write,
   output logic               mem_pc_src,
   output logic               wb_mem_to_reg,
   output logic               wb_reg_write
);

   localparam int IDEX_W  = $bits(full_ctl_t);
   localparam int EXMEM_W = $bits(late_ctl_t);
   localparam int MEMWB_W = $bits(wb_ctl_t);
   localparam logic [INSTR_W-1:0] OP_MASK =
      INSTR_W'(((64'd1 << OP_W) - 64'd1) << OP_LSB);

   generate
      if (OP_LSB + OP_W > INSTR_W) begin : g_bad_field
         $error("opcode field exceeds instruction width");
      end
      if (OPC_LOAD == OPC_STORE || OPC_LOAD == OPC_REG || OPC_LOAD == OPC_BEQ ||
          OPC_STORE == OPC_REG || OPC_STORE == OPC_BEQ || OPC_REG == OPC_BEQ) begin : g_bad_opc
         $error("opcode parameters must be distinct");
      end
   endgenerate

   logic [OP_W-1:0] opcode;
   logic            unused_low_bits;
   full_ctl_t       dec_ctl;
   full_ctl_t       idex_d, idex_q;
   late_ctl_t       exmem_q;
   wb_ctl_t         memwb_q;

   assign opcode          = instr_id[OP_LSB +: OP_W];
   assign unused_low_bits = ^(instr_id & ~OP_MASK);

   ctrl_decode #(
      .OP_W(OP_W), .OPC_LOAD(OPC_LOAD), .OPC_STORE(OPC_STORE),
      .OPC_REG(OPC_REG), .OPC_BEQ(OPC_BEQ)
   ) u_dec (
      .opcode (opcode),
      .ctl    (dec_ctl)
   );

   assign idex_d = bubble_req ? full_ctl_t'('0) : dec_ctl;

   ctrl_stage_reg #(.W(IDEX_W)) u_idex (
      .clk (clk), .rst (rst), .clr (flush_idex),
      .d   (idex_d), .q (idex_q)
   );

   ctrl_stage_reg #(.W(EXMEM_W)) u_exmem (
      .clk (clk), .rst (rst), .clr (flush_exmem),
      .d   (idex_q.late), .q (exmem_q)
   );

   ctrl_stage_reg #(.W(MEMWB_W)) u_memwb (
      .clk (clk), .rst (rst), .clr (1'b0),
      .d   (exmem_q.wb), .q (memwb_q)
   );

   assign ex_reg_dst    = idex_q.ex.reg_dst;
   assign ex_alu_src    = idex_q.ex.alu_src;
   assign ex_alu_op     = idex_q.ex.alu_op;
   assign mem_branch    = exmem_q.mem.branch;
   assign mem_read      = exmem_q.mem.rd_en;
   assign mem_write     = exmem_q.mem.wr_en;
   assign mem_pc_src    = exmem_q.mem.branch & alu_zero;
   assign wb_mem_to_reg = memwb_q.mem_to_reg;
   assign wb_reg_write  = memwb_q.reg_write;

endmodule

// File: rtl/ctrl_stage_chk.sv
module ctrl_stage_chk (
   input logic       clk,
   input logic       rst,
   input logic       bubble_req,
   input logic       flush_idex,
   input logic       flush_exmem,
   input logic       alu_zero,
   input logic [8:0] idex_bits,
   input logic [4:0] exmem_bits,
   input logic       ex_reg_dst,
   input logic       ex_alu_src,
   input logic [1:0] ex_alu_op,
   input logic       mem_branch,
   input logic       mem_read,
   input logic       mem_write,
   input logic       mem_pc_src,
   input logic       wb_mem_to_reg,
   input logic       wb_reg_write
);

   AST_BUBBLE_ZEROES: assert property (@(posedge clk) disable iff (rst)
      bubble_req |=> (idex_bits == 9'd0 && !ex_reg_dst && !ex_alu_src && ex_alu_op == 2'b00)); // R8

   AST_FLUSH_IDEX: assert property (@(posedge clk) disable iff (rst)
      flush_idex |=> (idex_bits == 9'd0)); // R9

   AST_FLUSH_EXMEM: assert property (@(posedge clk) disable iff (rst)
      flush_exmem |=> (!mem_branch && !mem_read && !mem_write)); // R9

   AST_EX_TO_MEM: assert property (@(posedge clk) disable iff (rst)
      !flush_exmem |=> (exmem_bits == $past(idex_bits[4:0]))); // R7

   AST_MEM_TO_WB: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ({wb_mem_to_reg, wb_reg_write} == $past(exmem_bits[1:0]))); // R7

   AST_PC_SRC_NEEDS_BRANCH: assert property (@(posedge clk) disable iff (rst)
      mem_pc_src |-> (mem_branch && alu_zero)); // R10

   AST_NO_RD_WR_MIX: assert property (@(posedge clk) disable iff (rst)
      !(mem_read && mem_write)); // R3

endmodule

bind ctrl_stage_pipe ctrl_stage_chk u_chk (
   .clk           (clk),
   .rst           (rst),
   .bubble_req    (bubble_req),
   .flush_idex    (flush_idex),
   .flush_exmem   (flush_exmem),
   .alu_zero      (alu_zero),
   .idex_bits     (idex_q),
   .exmem_bits    (exmem_q),
   .ex_reg_dst    (ex_reg_dst),
   .ex_alu_src    (ex_alu_src),
   .ex_alu_op     (ex_alu_op),
   .mem_branch    (mem_branch),
   .mem_read      (mem_read),
   .mem_write     (mem_write),
   .mem_pc_src    (mem_pc_src),
   .wb_mem_to_reg (wb_mem_to_reg),
   .wb_reg_write  (wb_reg_write)
);

// File: tb/sim_ctrl_stage_pipe.sv
module sim_ctrl_stage_pipe;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr_id = 32'd0;
   logic        bubble_req = 1'b0, flush_idex = 1'b0, flush_exmem = 1'b0, alu_zero = 1'b0;
   logic        ex_reg_dst, ex_alu_src, mem_branch, mem_read, mem_write, mem_pc_src;
   logic        wb_mem_to_reg, wb_reg_write;
   logic [1:0]  ex_alu_op;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ctrl_stage_pipe u0 (
      .clk(clk), .rst(rst), .instr_id(instr_id), .bubble_req(bubble_req),
      .flush_idex(flush_idex), .flush_exmem(flush_exmem), .alu_zero(alu_zero),
      .ex_reg_dst(ex_reg_dst), .ex_alu_src(ex_alu_src), .ex_alu_op(ex_alu_op),
      .mem_branch(mem_branch), .mem_read(mem_read), .mem_write(mem_write),
      .mem_pc_src(mem_pc_src), .wb_mem_to_reg(wb_mem_to_reg), .wb_reg_write(wb_reg_write)
   );

   // control word: {reg_dst, alu_src, alu_op[1:0], branch, mem_read, mem_write, mem_to_reg, reg_write}
   function automatic logic [8:0] exp_decode(input logic [5:0] op);
      case (op)
         6'h23:   return 9'b0_1_00_0_1_0_1_1; // R2
         6'h2B:   return 9'b0_1_00_0_0_1_0_0; // R3
         6'h00:   return 9'b1_0_10_0_0_0_0_1; // R4
         6'h04:   return 9'b0_0_01_1_0_0_0_0; // R5
         default: return 9'd0;                // R6
      endcase
   endfunction

   logic [8:0] m_idex = '0;
   logic [4:0] m_exmem = '0;
   logic [1:0] m_memwb = '0;

   always @(posedge clk) begin
      if (rst) begin
         m_idex <= '0; m_exmem <= '0; m_memwb <= '0;
      end else begin
         m_idex  <= (flush_idex || bubble_req) ? 9'd0 : exp_decode(instr_id[31:26]);
         m_exmem <= flush_exmem ? 5'd0 : m_idex[4:0];
         m_memwb <= m_exmem[1:0];
      end
   end

   task automatic compare(input string tag);
      logic [9:0] act, exp;
      act = {ex_reg_dst, ex_alu_src, ex_alu_op, mem_branch, mem_read, mem_write,
             mem_pc_src, wb_mem_to_reg, wb_reg_write};
      exp = {m_idex[8:5], m_exmem[4:2], m_exmem[4] & alu_zero, m_memwb};
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
      end
   endtask

   task automatic drive(input logic [31:0] ins, input logic bub, input logic fi,
                        input logic fe, input logic z);
      instr_id = ins; bubble_req = bub; flush_idex = fi; flush_exmem = fe; alu_zero = z;
   endtask

   task automatic tick(input string tag);
      @(negedge clk);
      compare(tag);
   endtask

   localparam logic [31:0] FILL = 32'hFC00_0000;

   initial begin
      void'($urandom(32'd7321));
      rst = 1'b1;
      repeat (3) @(negedge clk);
      compare("R11");
      rst = 1'b0;

      // each opcode class run alone through all three stages
      drive(32'h8C43_0014, 0, 0, 0, 0); tick("R2"); drive(FILL, 0, 0, 0, 0); tick("R2"); tick("R2"); tick("R2");
      drive(32'hAC43_0014, 0, 0, 0, 0); tick("R3"); drive(FILL, 0, 0, 0, 0); tick("R3"); tick("R3"); tick("R3");
      drive(32'h0022_1820, 0, 0, 0, 0); tick("R4"); drive(FILL, 0, 0, 0, 0); tick("R4"); tick("R4"); tick("R4");
      drive(32'h1022_0008, 0, 0, 0, 1); tick("R5"); drive(FILL, 0, 0, 0, 1); tick("R5"); tick("R10"); tick("R5");
      drive(32'h1022_0008, 0, 0, 0, 0); tick("R10"); drive(FILL, 0, 0, 0, 0); tick("R10"); tick("R10"); tick("R10");
      drive(32'h2022_0001, 0, 0, 0, 1); tick("R6"); drive(FILL, 0, 0, 0, 1); tick("R6"); tick("R6"); tick("R6");
      // invalid opcode whose lower bits mimic a load opcode
      drive(32'hFC00_0000 | (32'h23 << 20), 0, 0, 0, 0); tick("R1");
      drive(32'h8FFF_FFFF, 0, 0, 0, 0); tick("R1"); drive(FILL, 0, 0, 0, 0); tick("R1"); tick("R1"); tick("R1");
      // bubble, then each flush point
      drive(32'h8C00_0000, 1, 0, 0, 0); tick("R8"); drive(FILL, 0, 0, 0, 0); tick("R8"); tick("R8");
      drive(32'h8C00_0000, 0, 1, 0, 0); tick("R9"); drive(FILL, 0, 0, 0, 0); tick("R9"); tick("R9");
      drive(32'h8C00_0000, 0, 0, 0, 0); tick("R9"); drive(FILL, 0, 0, 1, 0); tick("R9"); drive(FILL, 0, 0, 0, 0); tick("R9"); tick("R9");
      // reset in the middle of a full pipe
      drive(32'h0000_0020, 0, 0, 0, 0); tick("R11"); tick("R11"); tick("R11");
      rst = 1'b1; tick("R11"); rst = 1'b0; drive(FILL, 0, 0, 0, 0); tick("R11");

      // random streams
      for (int i = 0; i < 600; i++) begin
         logic [5:0] op;
         logic [25:0] low;
         int sel;
         sel = int'($urandom % 6);
         low = 26'($urandom);
         case (sel)
            0: op = 6'h23;
            1: op = 6'h2B;
            2: op = 6'h00;
            3: op = 6'h04;
            default: op = 6'($urandom);
         endcase
         drive({op, low}, ($urandom % 8) == 0, ($urandom % 10) == 0,
               ($urandom % 10) == 0, 1'($urandom));
         tick("R7");
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog t=%0t actual=running expected=finished", $time);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule